// File: doc/BRIEF.md
# Pushbutton and Power-Fail Reset Supervisor

This block drives a single active-low reset output, `rst_out_n`, from two causes. The first is a mechanical pushbutton, which arrives asynchronously and bounces. The block synchronizes it, debounces it, and acts on the moment the button is let go. At that point it produces a reset pulse of a fixed number of clock cycles. The second cause is a digital power-fail flag from an external supply comparator. While that flag is high the output stays low. Once the flag drops, the output stays low for a further recovery delay before it is released.

A bypass input, `osc_off`, reflects that the timing oscillator is switched off. When it is set, the recovery delay is skipped and the output goes high as soon as power is reported good. The power-fail cause always wins over the pushbutton cause. Setting the output low does not stop the button tracking: the debouncer keeps following the pin, so a later press and release is handled normally. The debounce, pulse and recovery lengths are parameters counted in clock cycles.

Top module: `rst_supervisor`

## Requirements
- R1: While `rst_n` is low, `rst_out_n` is 0. After reset, with `pwr_fail`=0 and `osc_off`=0, the first rising edge runs the recovery delay, so `rst_out_n` rises on the (RECOV_CYC+1)-th rising edge after reset release.
- R2: `btn_n` (0 = pressed, 1 = released) passes through a two-flop synchronizer. A new level is accepted only after the synchronized value has differed from the accepted level on DEB_CYC consecutive rising edges. A shorter excursion changes nothing, and the output stays high.
- R3: An accepted release while the output is high drives `rst_out_n` low on the (DEB_CYC+2)-th rising edge that samples `btn_n`=1. The output then stays low for exactly PULSE_CYC cycles.
- R4: An accepted press alone never drives the output low. A press made during a pulse does not lengthen it. Only a new accepted release after the output has returned high starts another pulse.
- R5: `rst_out_n` is 0 from the first rising edge that samples `pwr_fail`=1, and stays 0 for as long as `pwr_fail` stays 1.
- R6: With `osc_off`=0, `rst_out_n` rises on the (RECOV_CYC+1)-th rising edge that samples `pwr_fail`=0 after a fail.
- R7: With `osc_off`=1, `rst_out_n` rises on the first rising edge that samples `pwr_fail`=0. Setting `osc_off` during a recovery delay ends that delay on the next rising edge.
- R8: A `pwr_fail` during a pushbutton pulse abandons the pulse. Release timing then restarts from power-good under R6 or R7.
- R9: The debouncer keeps tracking the button while the output is low. A release accepted during a pulse, a fail or a recovery is dropped. A later press and release after the output is high gives a normal R3 pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all intervals are counted on it |
| rst_n | input | 1 | Asynchronous active-low block reset, released synchronously |
| btn_n | input | 1 | Raw pushbutton level, asynchronous, 0 = pressed |
| pwr_fail | input | 1 | Supply-below-threshold flag, synchronous to `clk` |
| osc_off | input | 1 | Oscillator-disabled control; 1 bypasses the recovery delay |
| rst_out_n | output | 1 | Registered active-low reset output |

## Verification
A wrong internal state shows at `rst_out_n` within a few cycles. A stuck or mis-sized debounce counter moves the falling edge away from cycle DEB_CYC+2, or makes a short glitch produce a pulse. A pulse or recovery counter with a wrong terminal value makes the low time one cycle or more off from PULSE_CYC or RECOV_CYC+1. A sequencer that lets the button override a fail, or that restarts on a release inside a pulse, shows up as a rising edge while power is bad or as an extra pulse after the first one. The bench compares the output against an independent model on every clock, so any such fault is caught in the cycle it first appears.

// File: rtl/rsup_pkg.sv
package rsup_pkg;
  // Sequencer phases of the reset output.
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,  // output released
    ST_PULSE = 2'd1,  // pushbutton pulse in progress
    ST_FAIL  = 2'd2,  // supply below threshold
    ST_RECOV = 2'd3   // waiting out the recovery delay
  } rsup_state_e;
endpackage

// File: rtl/rsup_sync.sv
module rsup_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic d_out
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign d_out = chain_q[STAGES-1];
endmodule

// File: rtl/rsup_debounce.sv
module rsup_debounce #(
  parameter int unsigned DEB_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic btn_sync,   // synchronized level, 1 = released
  output logic rel_evt     // one-cycle strobe: release accepted this edge
);
  localparam int unsigned DW = $clog2(DEB_CYC + 1);

  logic [DW-1:0] cnt_q, cnt_d;
  logic          lvl_q, lvl_d;
  logic          differ, done;

  always_comb begin
    differ  = (btn_sync != lvl_q);
    done    = differ && (cnt_q == DW'(DEB_CYC - 1));
    cnt_d   = (differ && !done) ? cnt_q + 1'b1 : '0;
    lvl_d   = done ? btn_sync : lvl_q;
    rel_evt = done && btn_sync;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lvl_q <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      lvl_q <= lvl_d;
    end
  end
endmodule

// File: rtl/rsup_seq.sv
module rsup_seq
  import rsup_pkg::*;
#(
  parameter int unsigned PULSE_CYC = 32,
  parameter int unsigned RECOV_CYC = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rel_evt,
  input  logic pwr_fail,
  input  logic osc_off,
  output logic rst_out_n
);
  localparam int unsigned LONGEST = (PULSE_CYC > RECOV_CYC) ? PULSE_CYC : RECOV_CYC;
  localparam int unsigned CW      = $clog2(LONGEST + 1);

  rsup_state_e   state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          pulse_done, recov_done;
  logic          out_q;

  always_comb begin
    pulse_done = (cnt_q == CW'(PULSE_CYC - 1));
    recov_done = (cnt_q == CW'(RECOV_CYC - 1));
    state_d    = state_q;
    cnt_d      = '0;
    cnt_en     = 1'b0;
    if (pwr_fail) begin
      state_d = ST_FAIL;   // fail wins over everything
      cnt_en  = 1'b1;
    end else begin
      unique case (state_q)
        ST_FAIL: begin
          state_d = osc_off ? ST_RUN : ST_RECOV;
          cnt_en  = 1'b1;
        end
        ST_RECOV: begin
          if (osc_off || recov_done) state_d = ST_RUN;
          else begin
            cnt_en = 1'b1;
            cnt_d  = cnt_q + 1'b1;
          end
        end
        ST_PULSE: begin
          if (pulse_done) state_d = ST_RUN;
          else begin
            cnt_en = 1'b1;
            cnt_d  = cnt_q + 1'b1;
          end
        end
        default: begin
          if (rel_evt) begin
            state_d = ST_PULSE;
            cnt_en  = 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_FAIL;
      out_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      out_q   <= (state_d == ST_RUN);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign rst_out_n = out_q;
endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor #(
  parameter int unsigned DEB_CYC   = 8,
  parameter int unsigned PULSE_CYC = 32,
  parameter int unsigned RECOV_CYC = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic btn_n,
  input  logic pwr_fail,
  input  logic osc_off,
  output logic rst_out_n
);
  logic btn_sync;
  logic rel_evt;

  rsup_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (btn_n),
    .d_out (btn_sync)
  );

  rsup_debounce #(.DEB_CYC(DEB_CYC)) u_deb (
    .clk      (clk),
    .rst_n    (rst_n),
    .btn_sync (btn_sync),
    .rel_evt  (rel_evt)
  );

  rsup_seq #(.PULSE_CYC(PULSE_CYC), .RECOV_CYC(RECOV_CYC)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .rel_evt   (rel_evt),
    .pwr_fail  (pwr_fail),
    .osc_off   (osc_off),
    .rst_out_n (rst_out_n)
  );
endmodule

// File: rtl/rsup_checker.sv
module rsup_checker (
  input logic clk,
  input logic rst_n,
  input logic pwr_fail,
  input logic osc_off,
  input logic rst_out_n,
  input logic rel_evt,
  input logic btn_sync
);
  // R1: output held low during block reset
  always_comb begin
    if (!rst_n) assert_low_in_reset_R1: assert (rst_out_n == 1'b0);
  end

  // R2: a release is only accepted while the synchronized pin reads released
  assert_rel_needs_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rel_evt |-> btn_sync);

  // R3: an accepted release with power good pulls the output low
  assert_rel_pulls_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_evt && rst_out_n && !pwr_fail) |=> !rst_out_n);

  // R4: with no release and no fail a released output stays high
  assert_no_spurious_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_out_n && !rel_evt && !pwr_fail) |=> rst_out_n);

  // R5: a sampled fail forces the output low on the next edge
  assert_fail_forces_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail |=> !rst_out_n);

  // R6: power-good with the oscillator running starts the delay, output still low
  assert_recov_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pwr_fail) && !pwr_fail && !osc_off) |=> !rst_out_n);

  // R7: power-good with the oscillator off releases at once
  assert_bypass_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pwr_fail) && !pwr_fail && osc_off) |=> rst_out_n);
endmodule

bind rst_supervisor rsup_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pwr_fail  (pwr_fail),
  .osc_off   (osc_off),
  .rst_out_n (rst_out_n),
  .rel_evt   (rel_evt),
  .btn_sync  (btn_sync)
);

// File: tb/rst_supervisor_tb.sv
module rst_supervisor_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEB   = 4;
  localparam int PULSE = 16;
  localparam int RECOV = 10;

  logic clk = 1'b0;
  logic rst_n, btn_n, pwr_fail, osc_off;
  logic rst_out_n;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  rst_supervisor #(.DEB_CYC(DEB), .PULSE_CYC(PULSE), .RECOV_CYC(RECOV)) u_dut (
    .clk(clk), .rst_n(rst_n), .btn_n(btn_n), .pwr_fail(pwr_fail),
    .osc_off(osc_off), .rst_out_n(rst_out_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  // mode: 0 released, 1 pulse, 2 fail, 3 recovery
  int m_s1, m_s2, m_lvl, m_dc, m_mode, m_tc;
  bit m_exp;
  string m_tag = "R1";

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 1; m_s2 = 1; m_lvl = 1; m_dc = 0; m_mode = 2; m_tc = 0;
      m_exp = 1'b0; m_tag = "R1";
    end else begin
      bit rel;
      rel = 1'b0;
      if (m_s2 != m_lvl) begin
        if (m_dc == DEB - 1) begin m_lvl = m_s2; m_dc = 0; rel = (m_s2 == 1); end
        else m_dc++;
      end else m_dc = 0;
      m_s2 = m_s1; m_s1 = int'(btn_n);
      if (pwr_fail) begin
        if (m_mode == 1) m_tag = "R8"; else if (m_mode != 2) m_tag = "R5";
        m_mode = 2; m_tc = 0;
      end else begin
        case (m_mode)
          2: if (osc_off) begin m_mode = 0; m_tag = "R7"; end
             else begin m_mode = 3; m_tc = 0; if (m_tag != "R1") m_tag = "R6"; end
          3: if (osc_off) begin m_mode = 0; m_tag = "R7"; end
             else if (m_tc == RECOV - 1) m_mode = 0;
             else m_tc++;
          1: if (m_tc == PULSE - 1) begin m_mode = 0; m_tag = "R9"; end
             else m_tc++;
          default: if (rel) begin m_mode = 1; m_tc = 0; m_tag = "R3"; end
        endcase
      end
      m_exp = (m_mode == 0);
    end
  end

  // every-clock comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (!finished)
      check(rst_out_n === m_exp, m_tag, int'(rst_out_n), int'(m_exp));
  end

  // ---------------- measurement helpers ----------------
  task automatic edges_until(input logic lvl, output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (rst_out_n !== lvl && n < 500);
  endtask

  task automatic low_len(output int n);
    n = 0;
    while (rst_out_n === 1'b0 && n < 500) begin n++; @(negedge clk); end
  endtask

  task automatic lows_in(input int cyc, output int n);
    n = 0;
    repeat (cyc) begin @(negedge clk); if (rst_out_n !== 1'b1) n++; end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      finished = 1'b1;
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int n;
    rst_n = 1'b0; btn_n = 1'b1; pwr_fail = 1'b0; osc_off = 1'b0;
    repeat (3) @(negedge clk);
    check(rst_out_n === 1'b0, "R1", int'(rst_out_n), 0);
    rst_n = 1'b1;
    edges_until(1'b1, n);
    check(n == RECOV + 1, "R1", n, RECOV + 1);

    // R2: press glitch shorter than debounce
    @(negedge clk); btn_n = 1'b0;
    repeat (DEB - 1) @(negedge clk);
    btn_n = 1'b1;
    lows_in(20, n);
    check(n == 0, "R2", n, 0);

    // R4: long press alone, then release glitch while pressed
    btn_n = 1'b0;
    lows_in(20, n);
    check(n == 0, "R4", n, 0);
    btn_n = 1'b1;
    repeat (DEB - 1) @(negedge clk);
    btn_n = 1'b0;
    lows_in(20, n);
    check(n == 0, "R2", n, 0);

    // R3: real release, latency and pulse length
    btn_n = 1'b1;
    edges_until(1'b0, n);
    check(n == DEB + 2, "R3", n, DEB + 2);
    low_len(n);
    check(n == PULSE, "R3", n, PULSE);
    lows_in(10, n);
    check(n == 0, "R3", n, 0);

    // R4: press during pulse held past its end does not stretch it
    btn_n = 1'b0;
    repeat (DEB + 4) @(negedge clk);
    btn_n = 1'b1;
    edges_until(1'b0, n);
    btn_n = 1'b0;
    low_len(n);
    check(n == PULSE, "R4", n, PULSE);
    lows_in(20, n);
    check(n == 0, "R4", n, 0);
    btn_n = 1'b1;
    edges_until(1'b0, n);
    check(n == DEB + 2, "R4", n, DEB + 2);
    low_len(n);

    // R9: press and release both accepted inside a pulse are dropped
    btn_n = 1'b0;
    repeat (DEB + 4) @(negedge clk);
    btn_n = 1'b1;
    edges_until(1'b0, n);
    fork
      low_len(n);
      begin
        btn_n = 1'b0;
        repeat (DEB + 3) @(negedge clk);
        btn_n = 1'b1;
      end
    join
    check(n == PULSE, "R9", n, PULSE);
    lows_in(25, n);
    check(n == 0, "R9", n, 0);
    btn_n = 1'b0;
    repeat (DEB + 4) @(negedge clk);
    btn_n = 1'b1;
    edges_until(1'b0, n);
    check(n == DEB + 2, "R9", n, DEB + 2);
    low_len(n);
    check(n == PULSE, "R9", n, PULSE);

    // R5 / R6: fail while released, long hold, recovery
    repeat (5) @(negedge clk);
    pwr_fail = 1'b1;
    @(negedge clk);
    check(rst_out_n === 1'b0, "R5", int'(rst_out_n), 0);
    lows_in(30, n);
    check(n == 30, "R5", n, 30);
    pwr_fail = 1'b0;
    edges_until(1'b1, n);
    check(n == RECOV + 1, "R6", n, RECOV + 1);

    // R7: bypass with oscillator off
    pwr_fail = 1'b1; osc_off = 1'b1;
    repeat (5) @(negedge clk);
    pwr_fail = 1'b0;
    edges_until(1'b1, n);
    check(n == 1, "R7", n, 1);
    // R7: oscillator turned off mid-recovery
    osc_off = 1'b0; pwr_fail = 1'b1;
    repeat (4) @(negedge clk);
    pwr_fail = 1'b0;
    repeat (4) @(negedge clk);
    check(rst_out_n === 1'b0, "R6", int'(rst_out_n), 0);
    osc_off = 1'b1;
    @(negedge clk);
    check(rst_out_n === 1'b1, "R7", int'(rst_out_n), 1);
    osc_off = 1'b0;

    // R8: fail in the middle of a pushbutton pulse
    repeat (5) @(negedge clk);
    btn_n = 1'b0;
    repeat (DEB + 4) @(negedge clk);
    btn_n = 1'b1;
    edges_until(1'b0, n);
    repeat (3) @(negedge clk);
    pwr_fail = 1'b1;
    repeat (2) @(negedge clk);
    pwr_fail = 1'b0;
    edges_until(1'b1, n);
    check(n == RECOV + 1, "R8", n, RECOV + 1);
    lows_in(20, n);
    check(n == 0, "R8", n, 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule